// File: doc/BRIEF.md
# Accumulator Requantization Output Stage

This block turns a 32-bit signed accumulator into an 8-bit or 16-bit output value. It is meant to sit behind a multiply-accumulate datapath. Each accepted accumulator is multiplied by a signed range factor. The product is then shifted left or right by a signed scale amount, and right shifts round to nearest. A signed offset is added, an optional ReLU clamps negative values to zero, and the value saturates to the bounds of the selected output type. The result leaves the block as two byte registers, one for the low byte and one for the high byte.

The configuration is sampled in the same cycle as the accumulator strobe and travels down the pipeline with its data. A new accumulator can therefore be accepted every cycle, each with its own settings, and later changes to the configuration never touch values already in flight. The latency is fixed at three cycles.

Top module: `acc_requant`

## Requirements
- R1: While `rst_n` is low and afterwards until a new result emerges, `out_valid` is 0 and `out_lo`/`out_hi` are 0x00. A reset in mid-flight discards every value in the pipeline.
- R2: An accumulator accepted with `in_valid`=1 at a rising edge produces `out_valid`=1 with its result exactly three rising edges later. One value is accepted per cycle. All `cfg_*` inputs are sampled at that same edge.
- R3: The accumulator is multiplied by `cfg_range`, read as signed 16-bit. A `cfg_scale` in 0..31 (6-bit two's complement, bit 5 = 0) shifts the product left by that amount. Nothing is lost in an intermediate stage before saturation.
- R4: A `cfg_scale` in -32..-1 shifts the product right by its magnitude and rounds to nearest. Exact halves round away from zero (12.5 gives 13, -12.5 gives -13, 1.25 gives 1).
- R5: `cfg_offset`, read as signed 16-bit, is added after the shift and before ReLU and saturation.
- R6: With `cfg_relu`=1, a negative shifted-plus-offset value becomes 0 before saturation.
- R7: The result saturates to the selected type. `cfg_wide`=1 selects 16-bit and `cfg_wide`=0 selects 8-bit. `cfg_unsigned`=1 selects unsigned bounds (0..255 or 0..65535) and `cfg_unsigned`=0 selects signed bounds (-128..127 or -32768..32767).
- R8: In 16-bit mode `out_lo` carries result bits 7:0 and `out_hi` carries bits 15:8. In 8-bit mode `out_lo` carries the byte. `out_hi` is then 0xFF if the mode is signed and the byte is negative, and 0x00 otherwise.
- R9: In a cycle with `out_valid`=0, `out_lo` and `out_hi` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Accumulator strobe |
| in_acc | input | 32 | Signed accumulator |
| cfg_range | input | 16 | Signed multiplier |
| cfg_scale | input | 6 | Signed shift: positive shifts left, negative shifts right |
| cfg_offset | input | 16 | Signed offset added after the shift |
| cfg_wide | input | 1 | 1 = 16-bit result, 0 = 8-bit result |
| cfg_unsigned | input | 1 | 1 = unsigned saturation bounds |
| cfg_relu | input | 1 | 1 = clamp negative values to zero |
| out_valid | output | 1 | Result strobe |
| out_lo | output | 8 | Low result byte |
| out_hi | output | 8 | High result byte |

## Verification
The bench builds the block with its default parameters: a 32-bit accumulator, 16-bit range and offset, a 6-bit scale and 8-bit bytes. With these values the whole scale span is reachable, including the extreme left shift of 31 and the extreme right shift of 32. So is the product of the largest accumulator with the most negative range, which rounds to exactly the 16-bit signed minimum. The vector stream changes mode on every cycle and carries junk configuration in idle cycles. This exercises per-value configuration capture and byte holding as well as all four saturation bounds.

// File: rtl/rq_pkg.sv
// Shared types for the requantization output stage.
// Assumes: nothing beyond the standard packed-struct semantics.
package rq_pkg;

    // Output-type selection that rides down the pipeline with each value.
    typedef struct packed {
        logic wide;      // 1: 16-bit result, 0: 8-bit result
        logic uns;       // 1: unsigned saturation bounds
        logic relu;      // 1: clamp negatives to zero
    } rq_mode_t;

endpackage

// File: rtl/rq_mul_stage.sv
// Stage 1: captures the accumulator together with its configuration and
// registers the signed product of accumulator and range.
// Assumes: PROD_W == ACC_W + RNG_W, so the product never overflows.
module rq_mul_stage
    import rq_pkg::*;
#(
    parameter int ACC_W  = 32,
    parameter int RNG_W  = 16,
    parameter int SCL_W  = 6,
    parameter int OFF_W  = 16,
    parameter int PROD_W = 48
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     v_in,
    input  logic [ACC_W-1:0]         acc_in,
    input  logic [RNG_W-1:0]         rng_in,
    input  logic [SCL_W-1:0]         scl_in,
    input  logic [OFF_W-1:0]         off_in,
    input  rq_mode_t                 mode_in,
    output logic                     v_out,
    output logic signed [PROD_W-1:0] prod_out,
    output logic [SCL_W-1:0]         scl_out,
    output logic signed [OFF_W-1:0]  off_out,
    output rq_mode_t                 mode_out
);

    // Signed views of the operands.
    logic signed [ACC_W-1:0] acc_s;
    logic signed [RNG_W-1:0] rng_s;

    assign acc_s = acc_in;
    assign rng_s = rng_in;

    // Valid pipeline bit; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) v_out <= 1'b0;
        else        v_out <= v_in;
    end

    // Product and configuration capture, only for accepted values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_out <= '0;
            scl_out  <= '0;
            off_out  <= '0;
            mode_out <= '0;
        end else if (v_in) begin
            prod_out <= acc_s * rng_s;
            scl_out  <= scl_in;
            off_out  <= off_in;
            mode_out <= mode_in;
        end
    end

endmodule

// File: rtl/rq_shift_stage.sv
// Stage 2: applies the signed scale to the product. A non-negative scale
// shifts left into a widened word. A negative scale shifts right by its
// magnitude and rounds half away from zero (sign-magnitude rounding).
// Assumes: WIDE_W >= PROD_W + 2**(SCL_W-1) - 1, so left shifts lose nothing.
module rq_shift_stage
    import rq_pkg::*;
#(
    parameter int PROD_W = 48,
    parameter int SCL_W  = 6,
    parameter int OFF_W  = 16,
    parameter int WIDE_W = 80
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     v_in,
    input  logic signed [PROD_W-1:0] prod_in,
    input  logic [SCL_W-1:0]         scl_in,
    input  logic signed [OFF_W-1:0]  off_in,
    input  rq_mode_t                 mode_in,
    output logic                     v_out,
    output logic signed [WIDE_W-1:0] sh_out,
    output logic signed [OFF_W-1:0]  off_out,
    output rq_mode_t                 mode_out
);

    logic signed [WIDE_W-1:0] ext;
    logic                     go_left;
    logic [SCL_W-2:0]         lamt;
    logic [SCL_W-1:0]         ramt;
    logic                     neg;
    logic [WIDE_W-1:0]        mag;
    logic [WIDE_W-1:0]        half;
    logic [WIDE_W-1:0]        rmag;
    logic signed [WIDE_W-1:0] shifted;

    assign ext = WIDE_W'(prod_in);

    // Direction decode, magnitude rounding and sign restore.
    always_comb begin
        go_left = ~scl_in[SCL_W-1];
        lamt    = scl_in[SCL_W-2:0];
        ramt    = ~scl_in + SCL_W'(1);
        neg     = ext[WIDE_W-1];
        mag     = neg ? (~ext + WIDE_W'(1)) : ext;
        half    = WIDE_W'(1) << (ramt - SCL_W'(1));
        rmag    = (mag + half) >> ramt;
        if (go_left) shifted = ext <<< lamt;
        else if (neg) shifted = -$signed(rmag);
        else shifted = $signed(rmag);
    end

    // Valid pipeline bit; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) v_out <= 1'b0;
        else        v_out <= v_in;
    end

    // Shifted value and forwarded configuration, only for valid values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_out   <= '0;
            off_out  <= '0;
            mode_out <= '0;
        end else if (v_in) begin
            sh_out   <= shifted;
            off_out  <= off_in;
            mode_out <= mode_in;
        end
    end

endmodule

// File: rtl/rq_finish_stage.sv
// Stage 3: adds the offset, applies optional ReLU, saturates to the bounds
// of the selected output type and registers the result as byte lanes.
// The lanes hold their value while no valid result arrives.
// Assumes: the result is OUT_BYTES * BYTE_W wide and the narrow type is one byte.
module rq_finish_stage
    import rq_pkg::*;
#(
    parameter int WIDE_W    = 80,
    parameter int OFF_W     = 16,
    parameter int BYTE_W    = 8,
    parameter int OUT_BYTES = 2
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                v_in,
    input  logic signed [WIDE_W-1:0]            sh_in,
    input  logic signed [OFF_W-1:0]             off_in,
    input  rq_mode_t                            mode_in,
    output logic                                v_out,
    output logic [OUT_BYTES-1:0][BYTE_W-1:0]    lanes_out
);

    localparam int OUT_W  = OUT_BYTES * BYTE_W;
    localparam int SUM_W  = WIDE_W + 1;
    localparam int WS_MAX = (2 ** (OUT_W - 1)) - 1;
    localparam int WS_MIN = -(2 ** (OUT_W - 1));
    localparam int WU_MAX = (2 ** OUT_W) - 1;
    localparam int NS_MAX = (2 ** (BYTE_W - 1)) - 1;
    localparam int NS_MIN = -(2 ** (BYTE_W - 1));
    localparam int NU_MAX = (2 ** BYTE_W) - 1;

    logic signed [SUM_W-1:0] sum;
    logic signed [SUM_W-1:0] act;
    logic signed [SUM_W-1:0] lim_hi;
    logic signed [SUM_W-1:0] lim_lo;
    logic signed [SUM_W-1:0] clamped;
    logic [OUT_W-1:0]        res_q;

    // Offset addition and optional ReLU.
    always_comb begin
        sum = SUM_W'(sh_in) + SUM_W'(off_in);
        act = (mode_in.relu && sum < 0) ? '0 : sum;
    end

    // Saturation bounds for the selected output type.
    always_comb begin
        unique case ({mode_in.wide, mode_in.uns})
            2'b11:   begin lim_hi = SUM_W'(WU_MAX); lim_lo = '0;             end
            2'b10:   begin lim_hi = SUM_W'(WS_MAX); lim_lo = SUM_W'(WS_MIN); end
            2'b01:   begin lim_hi = SUM_W'(NU_MAX); lim_lo = '0;             end
            default: begin lim_hi = SUM_W'(NS_MAX); lim_lo = SUM_W'(NS_MIN); end
        endcase
    end

    // Clamp into range.
    always_comb begin
        if (act > lim_hi)      clamped = lim_hi;
        else if (act < lim_lo) clamped = lim_lo;
        else                   clamped = act;
    end

    // Valid pipeline bit; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) v_out <= 1'b0;
        else        v_out <= v_in;
    end

    // Result register; updated only by a valid value.
    always_ff @(posedge clk) begin
        if (!rst_n)    res_q <= '0;
        else if (v_in) res_q <= clamped[OUT_W-1:0];
    end

    // Byte-lane split of the registered result. The narrow type is clamped
    // in the full-width word, so the upper lanes already hold its extension.
    for (genvar b = 0; b < OUT_BYTES; b++) begin : g_lane
        assign lanes_out[b] = res_q[b*BYTE_W +: BYTE_W];
    end

endmodule

// File: rtl/acc_requant.sv
// Top of the requantization output stage: multiply -> shift/round ->
// offset/ReLU/saturate, three registered stages. The configuration is sampled
// with in_valid and travels with its value.
// Assumes: a single clock and a synchronous active-low reset.
module acc_requant
    import rq_pkg::*;
#(
    parameter int ACC_W  = 32,
    parameter int RNG_W  = 16,
    parameter int SCL_W  = 6,
    parameter int OFF_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ACC_W-1:0]  in_acc,
    input  logic [RNG_W-1:0]  cfg_range,
    input  logic [SCL_W-1:0]  cfg_scale,
    input  logic [OFF_W-1:0]  cfg_offset,
    input  logic              cfg_wide,
    input  logic              cfg_unsigned,
    input  logic              cfg_relu,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_lo,
    output logic [BYTE_W-1:0] out_hi
);

    localparam int PROD_W    = ACC_W + RNG_W;
    localparam int WIDE_W    = PROD_W + (2 ** (SCL_W - 1));
    localparam int OUT_BYTES = 2;

    rq_mode_t                      in_mode;
    logic                          v1, v2;
    logic signed [PROD_W-1:0]      prod1;
    logic [SCL_W-1:0]              scl1;
    logic signed [OFF_W-1:0]       off1, off2;
    rq_mode_t                      mode1, mode2;
    logic signed [WIDE_W-1:0]      sh2;
    logic [OUT_BYTES-1:0][BYTE_W-1:0] lanes;

    assign in_mode = '{wide: cfg_wide, uns: cfg_unsigned, relu: cfg_relu};

    rq_mul_stage #(
        .ACC_W(ACC_W), .RNG_W(RNG_W), .SCL_W(SCL_W), .OFF_W(OFF_W), .PROD_W(PROD_W)
    ) u_mul (
        .clk(clk), .rst_n(rst_n), .v_in(in_valid), .acc_in(in_acc),
        .rng_in(cfg_range), .scl_in(cfg_scale), .off_in(cfg_offset),
        .mode_in(in_mode), .v_out(v1), .prod_out(prod1), .scl_out(scl1),
        .off_out(off1), .mode_out(mode1)
    );

    rq_shift_stage #(
        .PROD_W(PROD_W), .SCL_W(SCL_W), .OFF_W(OFF_W), .WIDE_W(WIDE_W)
    ) u_shift (
        .clk(clk), .rst_n(rst_n), .v_in(v1), .prod_in(prod1), .scl_in(scl1),
        .off_in(off1), .mode_in(mode1), .v_out(v2), .sh_out(sh2),
        .off_out(off2), .mode_out(mode2)
    );

    rq_finish_stage #(
        .WIDE_W(WIDE_W), .OFF_W(OFF_W), .BYTE_W(BYTE_W), .OUT_BYTES(OUT_BYTES)
    ) u_finish (
        .clk(clk), .rst_n(rst_n), .v_in(v2), .sh_in(sh2), .off_in(off2),
        .mode_in(mode2), .v_out(out_valid), .lanes_out(lanes)
    );

    assign out_lo = lanes[0];
    assign out_hi = lanes[1];

endmodule

// File: rtl/acc_requant_chk.sv
// Assertion checker for acc_requant, attached by bind. It keeps its own
// three-deep record of the accepted input strobes and mode bits, so that
// output properties can be judged against the mode of each result.
// Assumes: default byte width of 8.
module acc_requant_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       cfg_wide,
    input logic       cfg_unsigned,
    input logic       cfg_relu,
    input logic       out_valid,
    input logic [7:0] out_lo,
    input logic [7:0] out_hi
);

    logic [1:0] cyc;
    logic [2:0] vd, wd, ud, rd;

    // Cycles since reset, saturating at three.
    always_ff @(posedge clk) begin
        if (!rst_n)        cyc <= '0;
        else if (cyc != 3) cyc <= cyc + 2'd1;
    end

    // Input strobe and mode history, three deep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vd <= '0; wd <= '0; ud <= '0; rd <= '0;
        end else begin
            vd <= {vd[1:0], in_valid};
            wd <= {wd[1:0], cfg_wide};
            ud <= {ud[1:0], cfg_unsigned};
            rd <= {rd[1:0], cfg_relu};
        end
    end

    // R1: first cycle after reset carries no result and cleared bytes
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!out_valid && out_lo == 8'h00 && out_hi == 8'h00));

    // R2: output strobe follows the input strobe by exactly three cycles
    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd3) |-> (out_valid == vd[2]));

    // R9: bytes hold in cycles without a result
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc != 2'd0 && !out_valid) |-> ($stable(out_lo) && $stable(out_hi)));

    // R8: narrow-mode high byte is the sign extension or zero
    p_narrow_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cyc == 2'd3 && !wd[2]) |->
            (out_hi == (ud[2] ? 8'h00 : {8{out_lo[7]}})));

    // R6: with ReLU on, a signed result is never negative
    p_relu_nonneg_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cyc == 2'd3 && rd[2] && !ud[2]) |->
            (wd[2] ? !out_hi[7] : !out_lo[7]));

endmodule

bind acc_requant acc_requant_chk u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cfg_wide(cfg_wide),
    .cfg_unsigned(cfg_unsigned), .cfg_relu(cfg_relu), .out_valid(out_valid),
    .out_lo(out_lo), .out_hi(out_hi)
);

// File: tb/acc_requant_tb_top.sv
// Bench for acc_requant: a stream of table vectors, back to back, then
// directed reset checks.
module acc_requant_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 3;
    localparam int NV         = 22;

    typedef struct packed {
        logic        vld;
        logic [31:0] acc;
        logic [15:0] rng;
        logic [5:0]  scl;
        logic [15:0] off;
        logic        wide;
        logic        uns;
        logic        relu;
        logic [7:0]  ehi;
        logic [7:0]  elo;
        logic [3:0]  req;
    } vec_t;

    // vld, acc, range, scale, offset, wide, uns, relu, exp_hi, exp_lo, req
    localparam vec_t VECS [NV] = '{
        '{1'b1, 32'd100,      16'd3,     6'h00, 16'h0000, 1'b0,1'b0,1'b0, 8'h00,8'h7F, 4'd7}, // R7 300 -> 127
        '{1'b1, 32'd100,      16'd1,     6'h3D, 16'h0000, 1'b0,1'b0,1'b0, 8'h00,8'h0D, 4'd4}, // R4 12.5 -> 13
        '{1'b1, 32'hFFFFFF9C, 16'd1,     6'h3D, 16'h0000, 1'b0,1'b0,1'b0, 8'hFF,8'hF3, 4'd4}, // R4 -12.5 -> -13
        '{1'b1, 32'hFFFFFF9C, 16'd1,     6'h3D, 16'h0000, 1'b0,1'b0,1'b1, 8'h00,8'h00, 4'd6}, // R6 ReLU
        '{1'b0, 32'hDEADBEEF, 16'h7FFF,  6'h15, 16'h1234, 1'b1,1'b1,1'b1, 8'h00,8'h00, 4'd9}, // R9 idle, junk cfg
        '{1'b1, 32'd1000,     16'hFFFE,  6'h02, 16'd5,    1'b1,1'b0,1'b0, 8'hE0,8'hC5, 4'd5}, // R5/R3 -7995
        '{1'b1, 32'd40000,    16'd2,     6'h00, 16'h0000, 1'b1,1'b1,1'b0, 8'hFF,8'hFF, 4'd7}, // R7 wide uns max
        '{1'b1, 32'hFFFFFFFB, 16'd1,     6'h00, 16'h0000, 1'b1,1'b1,1'b0, 8'h00,8'h00, 4'd7}, // R7 wide uns min
        '{1'b1, 32'h7FFFFFFF, 16'h8000,  6'h21, 16'h0000, 1'b1,1'b0,1'b0, 8'h80,8'h00, 4'd4}, // R4 extreme -> -32768
        '{1'b1, 32'd7,        16'd1,     6'h3F, 16'h0000, 1'b0,1'b1,1'b0, 8'h00,8'h04, 4'd4}, // R4 3.5 -> 4
        '{1'b1, 32'd200,      16'd1,     6'h00, 16'hFFF6, 1'b0,1'b1,1'b0, 8'h00,8'hBE, 4'd5}, // R5 200-10
        '{1'b1, 32'd3,        16'd5,     6'h1F, 16'h0000, 1'b1,1'b0,1'b0, 8'h7F,8'hFF, 4'd3}, // R3 shift 31, sat
        '{1'b1, 32'hFFFFFFFF, 16'd1,     6'h20, 16'h0000, 1'b0,1'b0,1'b0, 8'h00,8'h00, 4'd4}, // R4 shift 32
        '{1'b1, 32'd6,        16'd1,     6'h3E, 16'h0000, 1'b0,1'b0,1'b0, 8'h00,8'h02, 4'd4}, // R4 1.5 -> 2
        '{1'b1, 32'hFFFFFFFA, 16'd1,     6'h3E, 16'h0000, 1'b0,1'b0,1'b0, 8'hFF,8'hFE, 4'd8}, // R8 sign ext
        '{1'b0, 32'd55,       16'h8000,  6'h00, 16'h8000, 1'b0,1'b0,1'b0, 8'h00,8'h00, 4'd9}, // R9 idle
        '{1'b0, 32'd0,        16'h0001,  6'h3F, 16'h7FFF, 1'b1,1'b0,1'b1, 8'h00,8'h00, 4'd9}, // R9 idle
        '{1'b1, 32'd5,        16'd1,     6'h3E, 16'h0000, 1'b0,1'b0,1'b0, 8'h00,8'h01, 4'd4}, // R4 1.25 -> 1
        '{1'b1, 32'hFFFFFED4, 16'd1,     6'h00, 16'd100,  1'b1,1'b0,1'b1, 8'h00,8'h00, 4'd6}, // R6 -200 -> 0
        '{1'b1, 32'hFFFFFED4, 16'd1,     6'h00, 16'd100,  1'b1,1'b0,1'b0, 8'hFF,8'h38, 4'd8}, // R8 -200 wide
        '{1'b1, 32'h00012345, 16'd1,     6'h00, 16'h0000, 1'b1,1'b0,1'b0, 8'h7F,8'hFF, 4'd7}, // R7 wide sat
        '{1'b1, 32'd1,        16'd1,     6'h06, 16'h0000, 1'b0,1'b0,1'b0, 8'h00,8'h40, 4'd3}  // R3 left 6
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_acc = '0;
    logic [15:0] cfg_range = '0;
    logic [5:0]  cfg_scale = '0;
    logic [15:0] cfg_offset = '0;
    logic        cfg_wide = 1'b0;
    logic        cfg_unsigned = 1'b0;
    logic        cfg_relu = 1'b0;
    logic        out_valid;
    logic [7:0]  out_lo, out_hi;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_requant dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_acc(in_acc),
        .cfg_range(cfg_range), .cfg_scale(cfg_scale), .cfg_offset(cfg_offset),
        .cfg_wide(cfg_wide), .cfg_unsigned(cfg_unsigned), .cfg_relu(cfg_relu),
        .out_valid(out_valid), .out_lo(out_lo), .out_hi(out_hi)
    );

    task automatic check(input string tag, input logic v, input logic [7:0] hi,
                         input logic [7:0] lo, input logic ev,
                         input logic [7:0] ehi, input logic [7:0] elo);
        checks++;
        if (v !== ev || hi !== ehi || lo !== elo) begin
            errors++;
            $display("FAIL %s: got valid=%0b hi=%02h lo=%02h, expected valid=%0b hi=%02h lo=%02h",
                     tag, v, hi, lo, ev, ehi, elo);
        end
    endtask

    task automatic drive(input vec_t x);
        in_valid     = x.vld;
        in_acc       = x.acc;
        cfg_range    = x.rng;
        cfg_scale    = x.scl;
        cfg_offset   = x.off;
        cfg_wide     = x.wide;
        cfg_unsigned = x.uns;
        cfg_relu     = x.relu;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] last_hi, last_lo;
        repeat (3) @(negedge clk);
        // R1: values during reset
        check("R1 in reset", out_valid, out_hi, out_lo, 1'b0, 8'h00, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: state after reset release
        check("R1 after reset", out_valid, out_hi, out_lo, 1'b0, 8'h00, 8'h00);

        // Stream: drive vector c at each negedge, check vector c-LAT (R2 timing).
        last_hi = 8'h00;
        last_lo = 8'h00;
        for (int c = 0; c < NV + LAT; c++) begin
            if (c >= LAT) begin
                vec_t e;
                e = VECS[c - LAT];
                if (e.vld) begin
                    check($sformatf("R%0d/R2 vec %0d", e.req, c - LAT), out_valid,
                          out_hi, out_lo, 1'b1, e.ehi, e.elo);
                    last_hi = e.ehi;
                    last_lo = e.elo;
                end else begin
                    check($sformatf("R%0d vec %0d hold", e.req, c - LAT), out_valid,
                          out_hi, out_lo, 1'b0, last_hi, last_lo);
                end
            end
            if (c < NV) drive(VECS[c]);
            else drive('{1'b0, 32'hA5A5A5A5, 16'h1111, 6'h3F, 16'h2222, 1'b1, 1'b1, 1'b1,
                         8'h00, 8'h00, 4'd9});
            @(negedge clk);
        end
        // R9: bytes still hold after idle cycles
        check("R9 final hold", out_valid, out_hi, out_lo, 1'b0, last_hi, last_lo);

        // R1: reset in mid-flight discards the values in the pipeline
        drive('{1'b1, 32'd50, 16'd1, 6'h00, 16'h0000, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 4'd1});
        @(negedge clk);
        drive('{1'b1, 32'd60, 16'd1, 6'h00, 16'h0000, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 4'd1});
        rst_n = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check($sformatf("R1 flush %0d", k), out_valid, out_hi, out_lo, 1'b0, 8'h00, 8'h00);
        end

        // R2: one value after the flush, exactly three cycles later
        drive('{1'b1, 32'd9, 16'd2, 6'h00, 16'h0000, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 4'd2});
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check("R2 not yet (2)", out_valid, out_hi, out_lo, 1'b0, 8'h00, 8'h00);
        @(negedge clk);
        check("R2 lands (3)", out_valid, out_hi, out_lo, 1'b1, 8'h00, 8'h12);
        @(negedge clk);
        check("R2 single pulse", out_valid, out_hi, out_lo, 1'b0, 8'h00, 8'h12);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule